// File: doc/BRIEF.md
# Generation-Tagged Event Queue Writer

This block appends 32-bit event words to a circular queue that lives in memory. A request carries the event payload together with the queue's descriptor fields: the queue base address, a size code, the current write index and the current generation bit. The block forms the entry address and the tagged entry word. It issues one memory write with a valid/ready handshake and waits for the write response. It then reports the advanced index and generation on a descriptor write-back handshake.

The top bit of every stored entry carries the generation. The generation inverts each time the index wraps, so a consumer can tell fresh entries from stale ones without reading a producer pointer. A failed memory write abandons the update: no write-back is produced, and a one-cycle error pulse is raised instead.

Top module: `evq_writer`

## Requirements
- R1: The queue holds 2^(size_code + 10) entries of 4 bytes. The write address is base + ((index mod entries) << 2), so an index beyond the queue is reduced modulo the entry count.
- R2: Memory data is big-endian by byte lane. `mem_wdata[7:0]` carries bits 31:24 of the tagged word, `mem_wdata[15:8]` bits 23:16, `mem_wdata[23:16]` bits 15:8 and `mem_wdata[31:24]` bits 7:0.
- R3: The tagged word is {generation, event[30:0]}. Bit 31 of the event is discarded.
- R4: The written-back index is (index + 1) mod entries.
- R5: The written-back generation is the inverse of the request generation when the new index is zero, and equal to it otherwise.
- R6: The written-back generation-flipped flag equals the new generation.
- R7: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_wdata` hold.
- R8: After a response with `resp_err` low, `wb_valid` rises on the next cycle. It then stays high with stable fields until `wb_ready` is seen.
- R9: After a response with `resp_err` high, `err_o` is high for exactly one cycle, no write-back occurs and the block returns to idle.
- R10: `busy` is high from the cycle after a request is accepted until the write-back handshake or error. A request presented while busy is ignored and produces no memory write.
- R11: After reset, `busy`, `mem_valid`, `wb_valid` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Enqueue request, accepted when not busy |
| req_base | input | ADDR_W | Queue base address |
| req_size | input | SIZE_W | Size code, entries = 2^(code+10) |
| req_index | input | IDX_W | Current write index |
| req_gen | input | 1 | Current generation bit |
| req_data | input | 32 | Event payload |
| busy | output | 1 | Operation in progress |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Entry byte address |
| mem_wdata | output | 32 | Tagged word, big-endian lanes |
| resp_valid | input | 1 | Write response present |
| resp_err | input | 1 | Write response reports failure |
| wb_valid | output | 1 | Descriptor write-back request |
| wb_ready | input | 1 | Write-back accepted |
| wb_index | output | IDX_W | Advanced index |
| wb_gen | output | 1 | New generation bit |
| wb_gen_flipped | output | 1 | Generation-flipped flag |
| err_o | output | 1 | One-cycle pulse on a failed write |

## Verification
The bench builds the block with ADDR_W = 32 and IDX_W = 12. Size codes 0, 1 and 2 therefore give queues of 1024, 2048 and 4096 entries, and the full wrap at each size is reached by presenting the last index directly. The narrow index also exercises the modulo reduction of an out-of-range index. Stalls on both handshakes, an error response and a request made while busy are covered.

// File: rtl/evq_writer.sv
module evq_writer #(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 16,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [IDX_W-1:0]  req_index,
  input  logic              req_gen,
  input  logic [31:0]       req_data,
  output logic              busy,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              resp_valid,
  input  logic              resp_err,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [IDX_W-1:0]  wb_index,
  output logic              wb_gen,
  output logic              wb_gen_flipped,
  output logic              err_o
);
  typedef enum logic [1:0] {S_IDLE, S_MEM, S_RESP, S_WB} st_t;

  st_t               st;
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q, mask_q;
  logic              gen_q, err_q;
  logic [31:0]       word_q;

  logic [IDX_W-1:0]  span, mask_d, nxt_idx;
  logic              nxt_gen;

  assign span    = IDX_W'(1) << (32'(req_size) + 32'd10);
  assign mask_d  = span - IDX_W'(1);
  assign nxt_idx = (idx_q + IDX_W'(1)) & mask_q;
  assign nxt_gen = gen_q ^ (nxt_idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      base_q <= '0;
      idx_q  <= '0;
      mask_q <= '0;
      gen_q  <= 1'b0;
      word_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          st     <= S_MEM;
          base_q <= req_base;
          mask_q <= mask_d;
          idx_q  <= req_index & mask_d;
          gen_q  <= req_gen;
          word_q <= (req_data & 32'h7fff_ffff) | {req_gen, 31'b0};
        end
        S_MEM:  if (mem_ready) st <= S_RESP;
        S_RESP: if (resp_valid) begin
          st    <= resp_err ? S_IDLE : S_WB;
          err_q <= resp_err;
        end
        S_WB:   if (wb_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy           = (st != S_IDLE);
  assign mem_valid      = (st == S_MEM);
  assign mem_addr       = base_q + ADDR_W'({idx_q, 2'b00});
  assign mem_wdata      = {word_q[7:0], word_q[15:8], word_q[23:16], word_q[31:24]};
  assign wb_valid       = (st == S_WB);
  assign wb_index       = nxt_idx;
  assign wb_gen         = nxt_gen;
  assign wb_gen_flipped = nxt_gen;
  assign err_o          = err_q;
endmodule

// File: rtl/evq_writer_chk.sv
module evq_writer_chk #(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              resp_valid,
  input logic              resp_err,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [IDX_W-1:0]  wb_index,
  input logic              wb_gen,
  input logic              wb_gen_flipped,
  input logic              err_o
);
  p_addr_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);

  p_mem_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata));

  p_wb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_index) && $stable(wb_gen)
                              && $stable(wb_gen_flipped));

  p_ok_resp_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_valid && !wb_valid && resp_valid && !resp_err |=> wb_valid);

  p_err_no_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !wb_valid && !busy);

  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> busy && mem_valid);

  p_one_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_valid, wb_valid}) && ((mem_valid || wb_valid) -> busy));
endmodule

bind evq_writer evq_writer_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .resp_valid(resp_valid), .resp_err(resp_err),
  .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_index(wb_index),
  .wb_gen(wb_gen), .wb_gen_flipped(wb_gen_flipped), .err_o(err_o)
);

// File: tb/test_evq_writer.sv
module test_evq_writer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int IW = 12;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_base = '0;
  logic [SW-1:0] req_size = '0;
  logic [IW-1:0] req_index = '0;
  logic          req_gen = 1'b0;
  logic [31:0]   req_data = '0;
  logic          busy, mem_valid, wb_valid, wb_gen, wb_gen_flipped, err_o;
  logic          mem_ready = 1'b0, resp_valid = 1'b0, resp_err = 1'b0, wb_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [IW-1:0] wb_index;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evq_writer #(.ADDR_W(AW), .IDX_W(IW), .SIZE_W(SW)) i_evq_writer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
    .req_size(req_size), .req_index(req_index), .req_gen(req_gen),
    .req_data(req_data), .busy(busy), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .resp_valid(resp_valid), .resp_err(resp_err), .wb_valid(wb_valid),
    .wb_ready(wb_ready), .wb_index(wb_index), .wb_gen(wb_gen),
    .wb_gen_flipped(wb_gen_flipped), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic enqueue(input logic [AW-1:0] base, input int sz, input int idx,
                         input bit gen, input logic [31:0] data, input int mstall,
                         input int wstall, input bit err, input bit poke);
    int   entries = 1 << (sz + 10);
    int   eidx    = idx % entries;
    int   nidx    = (eidx + 1) % entries;
    bit   ngen    = gen ^ (nidx == 0);
    logic [31:0] tw = {gen, data[30:0]};
    logic [31:0] sw = {tw[7:0], tw[15:8], tw[23:16], tw[31:24]};
    logic [AW-1:0] eaddr = base + AW'(eidx * 4);
    @(negedge clk);
    req_valid = 1'b1; req_base = base; req_size = SW'(sz);
    req_index = IW'(idx); req_gen = gen; req_data = data;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    chk(mem_valid == 1'b1, "R10 mem_valid after accept", mem_valid, 1);
    chk(mem_addr == eaddr, "R1 address", mem_addr, eaddr);
    chk(mem_wdata == sw, "R2 R3 write data", mem_wdata, sw);
    if (poke) begin
      req_valid = 1'b1; req_data = 32'h1234_5678; req_index = IW'(7);
    end
    for (int i = 0; i < mstall; i++) begin
      @(negedge clk);
      chk(mem_valid && mem_addr == eaddr && mem_wdata == sw, "R7 hold during stall",
          mem_addr, eaddr);
    end
    req_valid = 1'b0;
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    chk(!mem_valid && busy, "R7 mem released", mem_valid, 0);
    resp_valid = 1'b1; resp_err = err;
    @(negedge clk);
    resp_valid = 1'b0; resp_err = 1'b0;
    if (err) begin
      chk(err_o == 1'b1, "R9 err pulse", err_o, 1);
      chk(!wb_valid && !busy, "R9 no write-back", wb_valid, 0);
      @(negedge clk);
      chk(err_o == 1'b0, "R9 err single cycle", err_o, 0);
      chk(!wb_valid && !mem_valid, "R9 stays idle", wb_valid, 0);
    end else begin
      chk(wb_valid == 1'b1, "R8 write-back raised", wb_valid, 1);
      chk(err_o == 1'b0, "R9 no err on success", err_o, 0);
      chk(wb_index == IW'(nidx), "R4 next index", wb_index, nidx);
      chk(wb_gen == ngen, "R5 generation", wb_gen, ngen);
      chk(wb_gen_flipped == ngen, "R6 flipped flag", wb_gen_flipped, ngen);
      for (int i = 0; i < wstall; i++) begin
        @(negedge clk);
        chk(wb_valid && wb_index == IW'(nidx) && wb_gen == ngen, "R8 hold during stall",
            wb_index, nidx);
      end
      wb_ready = 1'b1;
      @(negedge clk);
      wb_ready = 1'b0;
      chk(!busy && !wb_valid, "R10 idle after write-back", busy, 0);
    end
    if (poke) begin
      @(negedge clk);
      chk(!mem_valid && !busy, "R10 request while busy ignored", mem_valid, 0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !mem_valid && !wb_valid && !err_o, "R11 reset state",
        {busy, mem_valid, wb_valid, err_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    enqueue(32'h0001_0000, 0, 5, 1'b0, 32'h0000_00a5, 0, 0, 1'b0, 1'b0);
    enqueue(32'h0002_0000, 0, 9, 1'b1, 32'hdead_beef, 0, 0, 1'b0, 1'b0);
    enqueue(32'h0003_0000, 0, 1023, 1'b0, 32'h0102_0304, 0, 0, 1'b0, 1'b0);
    enqueue(32'h0004_0000, 1, 2047, 1'b1, 32'h7fff_ffff, 0, 0, 1'b0, 1'b0);
    enqueue(32'h0005_0000, 2, 3000, 1'b1, 32'h8000_0001, 0, 0, 1'b0, 1'b0);
    enqueue(32'h0006_0000, 2, 4095, 1'b0, 32'h5555_aaaa, 0, 0, 1'b0, 1'b0);
    enqueue(32'h0007_0000, 0, 1500, 1'b0, 32'h0000_0042, 0, 0, 1'b0, 1'b0);
    enqueue(32'h0008_0000, 1, 100, 1'b0, 32'hcafe_f00d, 3, 2, 1'b0, 1'b0);
    enqueue(32'h0009_0000, 0, 1023, 1'b1, 32'h0bad_0bad, 1, 0, 1'b1, 1'b0);
    enqueue(32'h000a_0000, 0, 12, 1'b0, 32'h1111_2222, 2, 1, 1'b0, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule